// File: doc/BRIEF.md
# Receive CRC-Withholding Byte Buffer

This block sits between a receive byte decoder and the write port of a receive FIFO. Decoded bytes arrive with a valid strobe and the received parity bit. The block checks the parity of each byte and keeps a running CRC over the frame. With CRC checking on, every byte passes through a small holding buffer that is as deep as the CRC field. As a result, the last one or two bytes of the frame, which form the CRC, are still inside the block when the frame ends.

Reception ends on an end-of-frame strobe or on a signal-lost strobe. If the CRC matches, the held bytes are dropped, so the FIFO receives only payload. If the CRC is wrong, or the frame is too short to hold a CRC, the held bytes are flushed to the FIFO one per cycle after the data. The block then pulses a done strobe, which the host logic uses as an interrupt source, and the CRC and parity error flags stay readable until the next frame begins.

Top module: `rx_crc_holdback`

## Requirements
- R1: With `crcEn`=0, each byte accepted while `inValid`=1 is written to the FIFO (`fifoWrite`=1, `fifoData`=byte) in the cycle after it is accepted, with no holding.
- R2: With `crcEn`=1, `crc8Sel`=1 selects a one-byte CRC field and `crc8Sel`=0 selects a two-byte CRC field. The held depth L is 1 or 2 to match.
- R3: With `crcEn`=1, bytes are written to the FIFO in arrival order, and byte k is written in the cycle after byte k+L is accepted.
- R4: A frame passes when its last L bytes equal the CRC of the bytes before them. In that case the L held bytes are never written. The two-byte CRC is reflected polynomial 0x8408 with initial value 0x6363, no final inversion, and is sent low byte first. The one-byte CRC is MSB-first polynomial 0x1D with initial value 0xFF, no final inversion.
- R5: With `crcEn`=1 and a failing CRC, `crcErr` becomes 1 in the cycle after the stop strobe. The held bytes are then written one per cycle, in order, beginning the cycle after that.
- R6: With `crcEn`=1, a frame of fewer than L bytes, including an empty one, sets `crcErr` and forwards every byte it received.
- R7: With `parityEn`=1, a byte sets `parityErr` when the XOR of its 8 data bits and `inParity` differs from `parityOdd` (1 = odd parity, 0 = even). With `parityEn`=0 the parity bit has no effect on `parityErr`.
- R8: `sigLost` ends a frame exactly as `frameEnd` does.
- R9: `done` is a one-cycle pulse. It comes one cycle after the last flushed write, or, when nothing is flushed, in the cycle after the stop strobe. No FIFO write happens while `done` is high.
- R10: `crcErr` and `parityErr` keep their values from the end of a frame until the first byte of the next frame clears them. `crcErr` is 0 for frames received with `crcEn`=0.
- R11: During reset, `fifoWrite`, `done`, `crcErr` and `parityErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| crcEn | input | 1 | CRC checking and holding enable |
| crc8Sel | input | 1 | 1: one-byte CRC, 0: two-byte CRC |
| parityEn | input | 1 | Parity checking enable |
| parityOdd | input | 1 | 1: odd parity, 0: even parity |
| inValid | input | 1 | Decoded byte strobe |
| inByte | input | 8 | Decoded byte |
| inParity | input | 1 | Received parity bit of the byte |
| frameEnd | input | 1 | End-of-frame strobe |
| sigLost | input | 1 | Signal below minimum level strobe |
| fifoWrite | output | 1 | FIFO write strobe |
| fifoData | output | 8 | FIFO write data |
| crcErr | output | 1 | CRC failure flag of the last frame |
| parityErr | output | 1 | Parity failure flag of the current or last frame |
| done | output | 1 | Reception finished pulse |

## Verification
The state most likely to go wrong is the hold count together with the running CRC. A wrong count makes a write appear one byte too early or too late, and that shows on `fifoWrite` within a cycle of the next accepted byte. A corrupted CRC register lets no error through until the stop strobe. It then shows one cycle later as a wrong `crcErr`, and as an extra or missing flush burst that moves `done` by one or two cycles. Because the model is compared every clock, any of these is caught in the cycle it first appears at a port.

// File: rtl/rxh_pkg.sv
package rxh_pkg;

  localparam int BYTE_W = 8;
  localparam logic [15:0] CRC16_POLY = 16'h8408;
  localparam logic [15:0] CRC16_INIT = 16'h6363;
  localparam logic [7:0]  CRC8_POLY  = 8'h1D;
  localparam logic [7:0]  CRC8_INIT  = 8'hFF;

  // Strobes from control to datapath, valid for one cycle each.
  typedef struct packed {
    logic newFrame;   // first event of a frame: clear flags, seed CRC
    logic take;       // accept inByte
    logic passThru;   // write inByte straight to the FIFO
    logic emitHead;   // write oldest held byte and shift
    logic closeFrame; // latch the CRC verdict
    logic finish;     // empty the buffer, end of reception
  } rxhCtl_t;

  function automatic logic [15:0] crc16Step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ CRC16_POLY) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] crc8Step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ CRC8_POLY) : (r << 1);
    return r;
  endfunction

endpackage

// File: rtl/rxh_datapath.sv
module rxh_datapath
  import rxh_pkg::*;
#(
  parameter int MAX_HOLD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxhCtl_t           ctl,
  input  logic              crcEn,
  input  logic              crc8Sel,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inParity,
  output logic              holdFull,
  output logic              holdEmpty,
  output logic              holdLast,
  output logic              crcOk,
  output logic              fifoWrite,
  output logic [BYTE_W-1:0] fifoData,
  output logic              crcErr,
  output logic              parityErr
);

  localparam int CNT_W = $clog2(MAX_HOLD + 1);

  logic [BYTE_W-1:0] holdBuf [MAX_HOLD];
  logic [CNT_W-1:0]  holdCount;
  logic [CNT_W-1:0]  holdLen;
  logic [15:0]       crcReg;
  logic [15:0]       crcBase;
  logic [15:0]       crcNext;
  logic              byteBad;

  assign holdLen   = crc8Sel ? CNT_W'(1) : CNT_W'(MAX_HOLD);
  assign holdFull  = (holdCount == holdLen);
  assign holdEmpty = (holdCount == '0);
  assign holdLast  = (holdCount == CNT_W'(1));
  assign crcOk     = holdFull && (crc8Sel ? (crcReg[7:0] == 8'h00) : (crcReg == 16'h0000));

  always_comb begin
    if (ctl.newFrame) crcBase = crc8Sel ? {8'h00, CRC8_INIT} : CRC16_INIT;
    else              crcBase = crcReg;
    if (crc8Sel) crcNext = {8'h00, crc8Step(crcBase[7:0], inByte)};
    else         crcNext = crc16Step(crcBase, inByte);
  end

  assign byteBad = parityEn && ((^{inByte, inParity}) != parityOdd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWrite <= 1'b0;
      fifoData  <= '0;
      holdCount <= '0;
      crcReg    <= CRC16_INIT;
      crcErr    <= 1'b0;
      parityErr <= 1'b0;
      for (int i = 0; i < MAX_HOLD; i++) holdBuf[i] <= '0;
    end else begin
      fifoWrite <= ctl.passThru | ctl.emitHead;
      if (ctl.passThru)      fifoData <= inByte;
      else if (ctl.emitHead) fifoData <= holdBuf[0];

      if (ctl.finish) begin
        holdCount <= '0;
      end else if (ctl.take && crcEn) begin
        crcReg <= crcNext;
        if (holdFull) begin
          for (int i = 0; i < MAX_HOLD; i++) begin
            if (i + 1 < int'(holdLen))       holdBuf[i] <= holdBuf[i+1];
            else if (i + 1 == int'(holdLen)) holdBuf[i] <= inByte;
          end
        end else begin
          for (int i = 0; i < MAX_HOLD; i++)
            if (i == int'(holdCount)) holdBuf[i] <= inByte;
          holdCount <= holdCount + CNT_W'(1);
        end
      end else if (ctl.emitHead) begin
        for (int i = 0; i < MAX_HOLD - 1; i++) holdBuf[i] <= holdBuf[i+1];
        holdCount <= holdCount - CNT_W'(1);
      end

      if (ctl.take)          parityErr <= (ctl.newFrame ? 1'b0 : parityErr) | byteBad;
      else if (ctl.newFrame) parityErr <= 1'b0;

      if (ctl.closeFrame)    crcErr <= crcEn & ~crcOk;
      else if (ctl.newFrame) crcErr <= 1'b0;
    end
  end

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(holdCount) <= MAX_HOLD);  // R3

  AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emitHead && !ctl.take) |=> (holdCount == $past(holdCount) - CNT_W'(1)));  // R5

endmodule

// File: rtl/rxh_control.sv
module rxh_control
  import rxh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    crcEn,
  input  logic    inValid,
  input  logic    stopRx,
  input  logic    holdFull,
  input  logic    holdEmpty,
  input  logic    holdLast,
  input  logic    crcOk,
  output rxhCtl_t ctl,
  output logic    done
);

  typedef enum logic [1:0] {ST_RECV, ST_FLUSH, ST_FIN} rxhState_t;

  rxhState_t state, stateNext;
  logic      inFrame;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    case (state)
      ST_RECV: begin
        if (inValid) begin
          ctl.take     = 1'b1;
          ctl.newFrame = !inFrame;
          ctl.passThru = !crcEn;
          ctl.emitHead = crcEn && holdFull;
        end else if (stopRx) begin
          ctl.closeFrame = 1'b1;
          ctl.newFrame   = !inFrame;
          if (crcEn && !crcOk && !holdEmpty) stateNext = ST_FLUSH;
          else                               ctl.finish = 1'b1;
        end
      end
      ST_FLUSH: begin
        ctl.emitHead = 1'b1;
        if (holdLast) stateNext = ST_FIN;
      end
      default: begin
        ctl.finish = 1'b1;
        stateNext  = ST_RECV;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RECV;
      inFrame <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctl.finish;
      if (ctl.finish)    inFrame <= 1'b0;
      else if (ctl.take) inFrame <= 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R9

  AST_FLUSH_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIN) |=> done);  // R9

endmodule

// File: rtl/rx_crc_holdback.sv
module rx_crc_holdback
  import rxh_pkg::*;
#(
  parameter int MAX_HOLD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              crcEn,
  input  logic              crc8Sel,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inParity,
  input  logic              frameEnd,
  input  logic              sigLost,
  output logic              fifoWrite,
  output logic [BYTE_W-1:0] fifoData,
  output logic              crcErr,
  output logic              parityErr,
  output logic              done
);

  rxhCtl_t ctl;
  logic    holdFull, holdEmpty, holdLast, crcOk;
  logic    stopRx;

  assign stopRx = frameEnd | sigLost;

  rxh_control u_control (
    .clk(clk), .rstN(rstN), .crcEn(crcEn), .inValid(inValid), .stopRx(stopRx),
    .holdFull(holdFull), .holdEmpty(holdEmpty), .holdLast(holdLast), .crcOk(crcOk),
    .ctl(ctl), .done(done)
  );

  rxh_datapath #(.MAX_HOLD(MAX_HOLD)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .crcEn(crcEn), .crc8Sel(crc8Sel),
    .parityEn(parityEn), .parityOdd(parityOdd), .inByte(inByte), .inParity(inParity),
    .holdFull(holdFull), .holdEmpty(holdEmpty), .holdLast(holdLast), .crcOk(crcOk),
    .fifoWrite(fifoWrite), .fifoData(fifoData), .crcErr(crcErr), .parityErr(parityErr)
  );

  AST_PASS_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (!crcEn && $past(!crcEn) && inValid && !done) |=> (fifoWrite && fifoData == $past(inByte)));  // R1

  AST_CRCERR_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcErr) |-> $past(stopRx));  // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !fifoWrite);  // R9

endmodule

// File: tb/sim_rx_crc_holdback.sv
module sim_rx_crc_holdback;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic crcEn = 1'b0, crc8Sel = 1'b0, parityEn = 1'b0, parityOdd = 1'b0;
  logic inValid = 1'b0, inParity = 1'b0, frameEnd = 1'b0, sigLost = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic fifoWrite, crcErr, parityErr, done;
  logic [7:0] fifoData;

  always #2.5 clk = ~clk;

  rx_crc_holdback u0 (
    .clk(clk), .rstN(rstN), .crcEn(crcEn), .crc8Sel(crc8Sel), .parityEn(parityEn),
    .parityOdd(parityOdd), .inValid(inValid), .inByte(inByte), .inParity(inParity),
    .frameEnd(frameEnd), .sigLost(sigLost), .fifoWrite(fifoWrite), .fifoData(fifoData),
    .crcErr(crcErr), .parityErr(parityErr), .done(done)
  );

  int nCmp = 0;
  int nBad = 0;

  task automatic check(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [15:0] refCrc16(input byte unsigned q[$], input int n);
    logic [15:0] c = 16'h6363;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ q[i][j];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  function automatic logic [7:0] refCrc8(input byte unsigned q[$], input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++)
      for (int j = 7; j >= 0; j--) begin
        logic fb = c[7] ^ q[i][j];
        c = c << 1;
        if (fb) c = c ^ 8'h1D;
      end
    return c;
  endfunction

  byte unsigned mHold[$];
  byte unsigned mFrame[$];
  bit mOpen = 0, mFlush = 0, mFin = 0;
  bit expW = 0, expDone = 0, expCE = 0, expPE = 0;
  byte unsigned expD = 0;
  string wTag = "R1";

  function automatic bit frameGood();
    int L = crc8Sel ? 1 : 2;
    int n = mFrame.size();
    logic [15:0] c;
    if (n < L) return 0;  // R6
    if (crc8Sel) return mFrame[n-1] == refCrc8(mFrame, n - 1);
    c = refCrc16(mFrame, n - 2);
    return (mFrame[n-2] == c[7:0]) && (mFrame[n-1] == c[15:8]);  // R4
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mHold.delete(); mFrame.delete();
      mOpen = 0; mFlush = 0; mFin = 0;
      expW = 0; expDone = 0; expCE = 0; expPE = 0;
    end else begin
      expW = 0; expDone = 0;
      if (mFin) begin
        expDone = 1; mFin = 0; mOpen = 0; mHold.delete();
      end else if (mFlush) begin
        expW = 1; expD = mHold.pop_front(); wTag = "R5";
        if (mHold.size() == 0) begin mFlush = 0; mFin = 1; end
      end else if (inValid) begin
        if (!mOpen) begin mOpen = 1; expPE = 0; expCE = 0; mFrame.delete(); end
        mFrame.push_back(inByte);
        if (parityEn && ((^{inByte, inParity}) != parityOdd)) expPE = 1;  // R7
        if (!crcEn) begin
          expW = 1; expD = inByte; wTag = "R1";
        end else begin
          mHold.push_back(inByte);
          if (mHold.size() > (crc8Sel ? 1 : 2)) begin
            expW = 1; expD = mHold.pop_front(); wTag = "R3";
          end
        end
      end else if (frameEnd || sigLost) begin  // R8
        bit ok;
        if (!mOpen) begin expPE = 0; mFrame.delete(); end
        ok = frameGood();
        expCE = crcEn && !ok;
        if (crcEn && !ok && mHold.size() > 0) mFlush = 1;
        else begin expDone = 1; mOpen = 0; mHold.delete(); end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check({wTag, " fifoWrite"}, fifoWrite, expW);
      if (expW) check({wTag, " fifoData"}, fifoData, expD);
      check("R9 done", done, expDone);
      check("R5 crcErr", crcErr, expCE);
      check("R7 parityErr", parityErr, expPE);
    end
  end

  // ---------------- stimulus ----------------
  byte unsigned txq[$];
  bit txFlip[$];
  int seed = 12345;

  function automatic int rnd(input int m);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fffff) % m;
  endfunction

  function automatic bit goodPar(input byte unsigned b, input bit odd);
    return odd ? ~(^b) : (^b);
  endfunction

  task automatic addCrc(input bit corrupt);
    if (crc8Sel) begin
      txq.push_back(refCrc8(txq, txq.size()));
      txFlip.push_back(0);
    end else begin
      logic [15:0] c = refCrc16(txq, txq.size());
      txq.push_back(c[7:0]); txq.push_back(c[15:8]);
      txFlip.push_back(0); txFlip.push_back(0);
    end
    if (corrupt) txq[txq.size()-1] = txq[txq.size()-1] ^ 8'h10;
  endtask

  task automatic cfg(input bit ce, input bit c8, input bit pe, input bit po);
    @(negedge clk);
    crcEn = ce; crc8Sel = c8; parityEn = pe; parityOdd = po;
  endtask

  task automatic sendFrame(input int gap, input bit useLost);
    for (int i = 0; i < txq.size(); i++) begin
      @(negedge clk);
      inValid = 1; inByte = txq[i];
      inParity = goodPar(txq[i], parityOdd) ^ txFlip[i];
      if (gap > 0) begin
        @(negedge clk); inValid = 0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    inValid = 0;
    if (useLost) sigLost = 1; else frameEnd = 1;
    @(negedge clk);
    frameEnd = 0; sigLost = 0;
    repeat (5) @(negedge clk);
    txq.delete(); txFlip.delete();
  endtask

  task automatic payload(input int n);
    for (int i = 0; i < n; i++) begin
      txq.push_back(byte'(rnd(256)));
      txFlip.push_back(0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs quiet during reset
    check("R11 fifoWrite", fifoWrite, 0);
    check("R11 done", done, 0);
    check("R11 crcErr", crcErr, 0);
    check("R11 parityErr", parityErr, 0);
    rstN = 1;

    // R1: CRC off, bytes pass straight through, back-to-back and spaced
    cfg(0, 0, 0, 0); payload(4); sendFrame(0, 0);
    cfg(0, 1, 0, 0); payload(3); sendFrame(2, 0);
    // R2 R3 R4: two-byte CRC, good, payload only reaches FIFO
    cfg(1, 0, 0, 0); payload(5); addCrc(0); sendFrame(0, 0);
    cfg(1, 0, 0, 0); payload(3); addCrc(0); sendFrame(1, 0);
    // R2 R4: one-byte CRC, good
    cfg(1, 1, 0, 0); payload(4); addCrc(0); sendFrame(0, 0);
    // R5: bad CRC flushes held bytes, both lengths
    cfg(1, 0, 0, 0); payload(4); addCrc(1); sendFrame(0, 0);
    cfg(1, 1, 0, 0); payload(2); addCrc(1); sendFrame(3, 0);
    // R6: short and empty frames
    cfg(1, 0, 0, 0); payload(1); sendFrame(0, 0);
    cfg(1, 0, 0, 0); sendFrame(0, 0);
    cfg(1, 1, 0, 0); sendFrame(0, 0);
    // R10: CRC-off frame after an error frame clears crcErr
    cfg(0, 0, 0, 0); payload(2); sendFrame(0, 0);
    // R7: odd and even parity with one bad byte, then parity disabled
    cfg(0, 0, 1, 1); payload(4); txFlip[2] = 1; sendFrame(0, 0);
    cfg(1, 0, 1, 0); payload(3); addCrc(0); txFlip[0] = 1; sendFrame(0, 0);
    cfg(0, 0, 1, 0); payload(3); sendFrame(0, 0);
    cfg(0, 0, 0, 1); payload(3); txFlip[1] = 1; sendFrame(0, 0);
    // R8: signal loss ends the frame like end of frame
    cfg(1, 0, 0, 0); payload(3); addCrc(0); sendFrame(0, 1);
    cfg(1, 1, 0, 0); payload(3); addCrc(1); sendFrame(0, 1);
    // mixed frames, every requirement R1..R10 under varied patterns
    for (int f = 0; f < 60; f++) begin
      cfg(rnd(4) != 0, rnd(2), rnd(2), rnd(2));
      payload(rnd(7));
      if (crcEn && rnd(5) != 0) addCrc(rnd(3) == 0);
      for (int k = 0; k < txFlip.size(); k++) txFlip[k] = (rnd(8) == 0);
      sendFrame(rnd(3), rnd(4) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule